// File: doc/BRIEF.md
# Read-While-Write Flash Access Controller

This controller sits between a CPU's fetch and load port and an on-chip flash array. The array is split at a fixed page boundary. The low pages form the read-while-write region, and the high pages form the no-read-while-write region. Any boot code lives in the high region. The controller accepts page erase and page write commands. It models each operation as a fixed run of clock cycles. It decides from the target page whether the CPU may keep running or must be stalled.

When a low-region page is being programmed, the CPU keeps running and can read the high region. The low region is held blocked behind a busy flag. That flag stays set after the operation ends, and only an explicit re-enable command clears it. When a high-region page is being programmed, the CPU is stalled for the whole operation and nothing is readable.

Any read the controller blocks returns all ones. It also sets a sticky violation flag, so a program that misbehaves gives a known result instead of undefined data.

Top module: `rww_flash_ctrl`

## Requirements
- R1: After reset the controller is idle, with `cpu_stall`, `rww_busy`, `rd_viol`, `op_done` and `cmd_err` low, and reads of either region return the array data.
- R2: A programming command whose page is below `RWW_PAGES` leaves `cpu_stall` low, and reads of high-region addresses return the array data during the operation without setting `rd_viol`.
- R3: A programming command whose page is at or above `RWW_PAGES` holds `cpu_stall` high for exactly `OP_CYCLES` cycles, starting the cycle after acceptance. Every read during that time returns all ones.
- R4: Accepting a low-region command sets `rww_busy` in the next cycle.
- R5: `rww_busy` stays high after the low-region operation completes, until a re-enable command (`cmd_op` = 2'b11) is issued while idle. The flag then clears in the next cycle.
- R6: A re-enable command issued while an operation is running is ignored, and `rww_busy` stays high.
- R7: A read of a low-region address while `rww_busy` is high returns all ones and sets `rd_viol`, which stays high until reset.
- R8: An operation lasts `OP_CYCLES` cycles after acceptance. `op_done` then pulses high for exactly one cycle.
- R9: An erase (`cmd_op` = 2'b01) or write (`cmd_op` = 2'b10) command arriving while an operation runs is rejected. `cmd_err` pulses high in the next cycle, and the running operation's page is unchanged.
- R10: A high-region operation never sets `rww_busy`, so the low region is readable right after it completes without any re-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | 01 erase, 10 write, 11 re-enable low region, 00 no-op |
| cmd_page | input | PAGE_W | Target page of erase or write |
| rd_en | input | 1 | CPU read request |
| rd_addr | input | ADDR_W | CPU word address; top PAGE_W bits are the page |
| rd_data | output | DATA_W | Read data, all ones when blocked |
| arr_rd_en | output | 1 | Read enable to the array, low when blocked |
| arr_addr | output | ADDR_W | Read address to the array |
| arr_rdata | input | DATA_W | Read data from the array |
| prog_active | output | 1 | Operation in progress |
| prog_op | output | 2 | Operation code being run |
| prog_page | output | PAGE_W | Page being programmed |
| cpu_stall | output | 1 | CPU halt request |
| rww_busy | output | 1 | Low region blocked for reading |
| rd_viol | output | 1 | Sticky: a blocked read was attempted |
| op_done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | One-cycle pulse: command rejected |

## Verification
The programming path is exercised with targets on both sides of the boundary. These include the first and last low pages (0 and 11) and the first and last high pages (12 and 15), so an off-by-one in the region compare changes both the stall and the busy result. Read checks look at high addresses during low-region programming and at low addresses while the busy flag is held. They tell the correct behaviour apart from a controller that blocks too much or too little. Two out-of-order inputs are sent during a running operation: a re-enable command and a second program command. These separate the ignore and reject rules from a normal accept. The cycle count to the done pulse confirms the operation length.

// File: rtl/rww_flash_ctrl.sv
module rww_flash_ctrl #(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 4,
  parameter int DATA_W    = 16,
  parameter int RWW_PAGES = 12,
  parameter int OP_CYCLES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [PAGE_W-1:0] cmd_page,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              arr_rd_en,
  output logic [ADDR_W-1:0] arr_addr,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              prog_active,
  output logic [1:0]        prog_op,
  output logic [PAGE_W-1:0] prog_page,
  output logic              cpu_stall,
  output logic              rww_busy,
  output logic              rd_viol,
  output logic              op_done,
  output logic              cmd_err
);
  localparam int CNT_W = (OP_CYCLES > 1) ? $clog2(OP_CYCLES) : 1;
  localparam logic [PAGE_W-1:0] BOUND = PAGE_W'(RWW_PAGES);
  localparam logic [CNT_W-1:0]  LOAD  = CNT_W'(OP_CYCLES - 1);
  localparam logic [1:0] OP_ERASE = 2'b01, OP_WRITE = 2'b10, OP_REEN = 2'b11;

  logic             active, tgt_hi, busy_q, viol_q, done_q, err_q;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       op_q;
  logic [PAGE_W-1:0] page_q;

  wire [PAGE_W-1:0] rd_page = rd_addr[ADDR_W-1 -: PAGE_W];
  wire is_prog  = cmd_valid && (cmd_op == OP_ERASE || cmd_op == OP_WRITE);
  wire accept   = is_prog && !active;
  wire reen     = cmd_valid && cmd_op == OP_REEN && !active;
  wire cmd_hi   = cmd_page >= BOUND;
  wire blocked  = (active && tgt_hi) || (busy_q && rd_page < BOUND);

  assign rd_data     = blocked ? '1 : arr_rdata;
  assign arr_rd_en   = rd_en && !blocked;
  assign arr_addr    = rd_addr;
  assign prog_active = active;
  assign prog_op     = op_q;
  assign prog_page   = page_q;
  assign cpu_stall   = active && tgt_hi;
  assign rww_busy    = busy_q;
  assign rd_viol     = viol_q;
  assign op_done     = done_q;
  assign cmd_err     = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      tgt_hi <= 1'b0;
      busy_q <= 1'b0;
      viol_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      cnt    <= '0;
      op_q   <= '0;
      page_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= is_prog && active;
      if (active) begin
        if (cnt == '0) begin
          active <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (accept) begin
        active <= 1'b1;
        cnt    <= LOAD;
        op_q   <= cmd_op;
        page_q <= cmd_page;
        tgt_hi <= cmd_hi;
        if (!cmd_hi) busy_q <= 1'b1;
      end else if (reen) begin
        busy_q <= 1'b0;
      end
      if (rd_en && blocked) viol_q <= 1'b1;
    end
  end

  AST_RWW_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !cmd_hi |=> !cpu_stall && rww_busy); // R2
  AST_NRWW_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cmd_hi |=> cpu_stall && !rww_busy); // R3
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rww_busy && !(cmd_valid && cmd_op == OP_REEN && !prog_active) |=> rww_busy); // R5
  AST_REEN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    prog_active && cmd_valid && cmd_op == OP_REEN |=> rww_busy == $past(rww_busy)); // R6
  AST_FILLER: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rww_busy && rd_page < BOUND |-> rd_data == '1 && !arr_rd_en); // R7
  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_viol |=> rd_viol); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> !prog_active ##1 !op_done); // R8
  AST_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    is_prog && prog_active && cnt != '0 |=> cmd_err && prog_active && $stable(prog_page)); // R9
endmodule

// File: tb/rww_flash_ctrl_tb.sv
module rww_flash_ctrl_tb;
  localparam int OPC = 6;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, rd_en = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [3:0] cmd_page = '0;
  logic [7:0] rd_addr = '0, arr_addr, prog_dummy;
  logic [15:0] rd_data, arr_rdata;
  logic arr_rd_en, prog_active, cpu_stall, rww_busy, rd_viol, op_done, cmd_err;
  logic [1:0] prog_op;
  logic [3:0] prog_page;
  int checks = 0, fails = 0;

  assign arr_rdata = {8'hA5, arr_addr};
  assign prog_dummy = '0;

  always #10 clk = ~clk;

  rww_flash_ctrl #(.ADDR_W(8), .PAGE_W(4), .DATA_W(16), .RWW_PAGES(12), .OP_CYCLES(OPC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_page(cmd_page),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .arr_rd_en(arr_rd_en),
    .arr_addr(arr_addr), .arr_rdata(arr_rdata), .prog_active(prog_active), .prog_op(prog_op),
    .prog_page(prog_page), .cpu_stall(cpu_stall), .rww_busy(rww_busy), .rd_viol(rd_viol),
    .op_done(op_done), .cmd_err(cmd_err));

  // {op[1:0], page[3:0], expected stall, expected busy}
  localparam logic [7:0] VEC [0:4] = '{
    8'b01_0000_0_1, 8'b10_1011_0_1, 8'b01_1100_1_0, 8'b10_1111_1_0, 8'b10_0101_0_1};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] op, input logic [3:0] pg);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_page = pg;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
    #1;
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string tag);
    rd_en = 1'b1; rd_addr = a;
    #1 check(tag, rd_data, exp);
    @(negedge clk);
    rd_en = 1'b0;
    #1;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!op_done && n < 100) begin
      @(negedge clk); #1; n++;
    end
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 stall", cpu_stall, 0);
    check("R1 busy", rww_busy, 0);
    check("R1 viol", rd_viol, 0);
    check("R1 done", op_done, 0);
    check("R1 err", cmd_err, 0);
    rd(8'h21, 16'hA521, "R1 low read");
    rd(8'hD3, 16'hA5D3, "R1 high read");

    // low-region programming
    cmd(2'b01, 4'd3);
    check("R2 no stall", cpu_stall, 0);
    check("R4 busy set", rww_busy, 1);
    rd(8'hD0, 16'hA5D0, "R2 high read during op");
    check("R2 no viol", rd_viol, 0);
    cmd(2'b11, 4'd0);
    check("R6 reenable ignored", rww_busy, 1);
    cmd(2'b10, 4'd7);
    check("R9 err pulse", cmd_err, 1);
    check("R9 page kept", prog_page, 3);
    @(negedge clk); #1;
    check("R9 err one cycle", cmd_err, 0);
    wait_done(n);
    check("R8 done seen", op_done, 1);
    @(negedge clk); #1;
    check("R5 busy after done", rww_busy, 1);
    rd(8'h30, 16'hFFFF, "R7 blocked filler");
    check("R7 viol set", rd_viol, 1);
    cmd(2'b11, 4'd0);
    check("R5 reenable clears", rww_busy, 0);
    rd(8'h30, 16'hA530, "R5 low readable");
    check("R7 viol sticky", rd_viol, 1);

    // high-region programming
    cmd(2'b10, 4'd14);
    check("R3 stall", cpu_stall, 1);
    check("R10 busy clear", rww_busy, 0);
    rd(8'hE0, 16'hFFFF, "R3 high read blocked");
    rd(8'h10, 16'hFFFF, "R3 low read blocked");
    wait_done(n);
    check("R3 stall ends", cpu_stall, 0);
    rd(8'h20, 16'hA520, "R10 low readable");

    // vector table
    for (int i = 0; i < 5; i++) begin
      cmd(VEC[i][7:6], VEC[i][5:2]);
      check($sformatf("R3 stall vec%0d", i), cpu_stall, VEC[i][1]);
      check($sformatf("R4 R10 busy vec%0d", i), rww_busy, VEC[i][0]);
      check($sformatf("R8 op code vec%0d", i), prog_op, VEC[i][7:6]);
      wait_done(n);
      check($sformatf("R8 length vec%0d", i), n, OPC);
      @(negedge clk); #1;
      check($sformatf("R8 pulse width vec%0d", i), op_done, 0);
      check($sformatf("R5 busy held vec%0d", i), rww_busy, VEC[i][0]);
      cmd(2'b11, 4'd0);
      check($sformatf("R5 cleared vec%0d", i), rww_busy, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule